// File: doc/BRIEF.md
# Wake Pin Trigger Detector

This block watches one asynchronous wake input and produces an event whenever the pin meets a programmed trigger condition. The condition can be a low level, a high level, a falling edge, a rising edge, or any change. It can also be switched off. The pin passes through a synchronizer chain before it is evaluated. Edge detection compares the newest synchronized sample with the sample one cycle older.

A single configuration word controls the block. Bits [3:1] hold the trigger mode. Bit 4 is a self-clearing detector reset. Bit 0 reads back the synchronized pin level. A surrounding controller places one instance per wake pin and supplies the bus decoding, status, enable and routing. It reads `wakeEvent` as a request.

A detector reset discards any transition still inside the synchronizer. Edge events are held off for as many cycles as the chain is deep. The edge reference is then rebuilt from the current pin level, so a transition that was in flight at the time of the write produces no event.

Top module: `wake_pin_detector`

## Requirements
- R1: After reset the mode field (bits [3:1]) reads 4 (disabled), `wakeEvent` is low, and bit 4 reads 0.
- R2: A write (`cfgWrEn` high for one cycle) loads bits [3:1] of `cfgWrData` into the mode field, and the new mode reads back from the cycle after the write. Bit 4 and bits [7:5] always read 0.
- R3: Bit 0 of `cfgRdData` reads the synchronized pin. It follows a pin change two clock edges after the change.
- R4: Mode 0 (level low) asserts `wakeEvent` in every cycle in which the synchronized pin is 0.
- R5: Mode 1 (level high) asserts `wakeEvent` in every cycle in which the synchronized pin is 1.
- R6: Mode 2 (falling edge) gives a one-cycle pulse for each 1-to-0 transition of the synchronized pin, and no pulse for rising transitions.
- R7: Mode 3 (rising edge) gives a one-cycle pulse for each 0-to-1 transition of the synchronized pin, and no pulse for falling transitions.
- R8: Mode 6 (any change) gives a one-cycle pulse for each transition of the synchronized pin, in either direction.
- R9: Modes 4, 5 and 7 never assert `wakeEvent`, whatever the pin level or its transitions.
- R10: A write with bit 4 set suppresses edge events for two cycles and rebuilds the edge reference. A pin transition that enters the synchronizer on the write cycle produces no event. Edge detection is normal afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pinAsync | input | 1 | Asynchronous wake pin |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data (bits [3:1] mode, bit 4 detector reset) |
| cfgRdData | output | 8 | Configuration read data (bit 0 synchronized pin, bits [3:1] mode) |
| wakeEvent | output | 1 | Trigger event (a level in the level modes, a pulse in the edge modes) |

## Verification
The hardest situation to reach from the ports is a pin transition that is still inside the synchronizer when a detector reset is written. Without the blanking, that transition would emerge as a spurious edge. The stimulus changes the pin on the same cycle as a write that selects rising-edge mode and sets the reset bit. It then watches `wakeEvent` for several cycles and confirms that no pulse appears. A later clean rising edge shows that detection has resumed.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

  localparam int MODE_W   = 3;
  localparam int MODE_LSB = 1;
  localparam int SRST_BIT = 4;
  localparam int PIN_BIT  = 0;

  localparam logic [MODE_W-1:0] MODE_LEVEL_LOW  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_LEVEL_HIGH = 3'd1;
  localparam logic [MODE_W-1:0] MODE_EDGE_FALL  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_EDGE_RISE  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_OFF        = 3'd4;
  localparam logic [MODE_W-1:0] MODE_EDGE_ANY   = 3'd6;

  // strobes from control to datapath
  typedef struct packed {
    logic levelEn;   // evaluate level rather than edges
    logic levelPol;  // level that triggers
    logic riseEn;
    logic fallEn;
    logic blankLoad; // detector reset requested this cycle
  } detStrobes_t;

endpackage

// File: rtl/wpd_ctrl.sv
module wpd_ctrl
  import wpd_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             pinSync,
  output logic [CFG_W-1:0] cfgRdData,
  output detStrobes_t      strb
);

  localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

  logic [MODE_W-1:0] modeQ;
  logic              unusedWrBits;

  assign unusedWrBits = ^{cfgWrData[CFG_W-1:SRST_BIT+1], cfgWrData[PIN_BIT]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= MODE_OFF;
    end else if (cfgWrEn) begin
      modeQ <= cfgWrData[MODE_MSB:MODE_LSB];
    end
  end

  always_comb begin
    strb           = '0;
    strb.blankLoad = cfgWrEn & cfgWrData[SRST_BIT];
    case (modeQ)
      MODE_LEVEL_LOW:  begin strb.levelEn = 1'b1; strb.levelPol = 1'b0; end
      MODE_LEVEL_HIGH: begin strb.levelEn = 1'b1; strb.levelPol = 1'b1; end
      MODE_EDGE_FALL:  strb.fallEn = 1'b1;
      MODE_EDGE_RISE:  strb.riseEn = 1'b1;
      MODE_EDGE_ANY:   begin strb.riseEn = 1'b1; strb.fallEn = 1'b1; end
      default:         ;
    endcase
  end

  always_comb begin
    cfgRdData                    = '0;
    cfgRdData[PIN_BIT]           = pinSync;
    cfgRdData[MODE_MSB:MODE_LSB] = modeQ;
  end

endmodule

// File: rtl/wpd_datapath.sv
module wpd_datapath
  import wpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pinAsync,
  input  detStrobes_t strb,
  output logic        pinSync,
  output logic        wakeEvent
);

  localparam int BLANK_W = $clog2(SYNC_STAGES + 1);
  localparam logic [BLANK_W-1:0] BLANK_LEN = BLANK_W'(SYNC_STAGES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevSample;
  logic [BLANK_W-1:0]     blankCnt;
  logic                   blanking;
  logic                   riseSeen;
  logic                   fallSeen;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= pinAsync;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], pinAsync};
      end
    end
  endgenerate

  assign pinSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevSample <= 1'b0;
      blankCnt   <= '0;
    end else begin
      prevSample <= pinSync;
      if (strb.blankLoad)      blankCnt <= BLANK_LEN;
      else if (blankCnt != '0) blankCnt <= blankCnt - 1'b1;
    end
  end

  assign blanking = (blankCnt != '0);
  assign riseSeen = pinSync & ~prevSample;
  assign fallSeen = ~pinSync & prevSample;

  always_comb begin
    if (strb.levelEn)
      wakeEvent = (pinSync == strb.levelPol);
    else
      wakeEvent = ~blanking & ((strb.riseEn & riseSeen) | (strb.fallEn & fallSeen));
  end

endmodule

// File: rtl/wake_pin_detector.sv
module wake_pin_detector
  import wpd_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pinAsync,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             wakeEvent
);

  detStrobes_t strb;
  logic        pinSync;

  wpd_ctrl #(.CFG_W(CFG_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .pinSync   (pinSync),
    .cfgRdData (cfgRdData),
    .strb      (strb)
  );

  wpd_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pinAsync  (pinAsync),
    .strb      (strb),
    .pinSync   (pinSync),
    .wakeEvent (wakeEvent)
  );

endmodule

// File: rtl/wpd_checker.sv
module wpd_checker #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfgWrEn,
  input logic [CFG_W-1:0] cfgWrData,
  input logic [CFG_W-1:0] cfgRdData,
  input logic             wakeEvent
);

  logic [2:0] modeRd;
  logic       oneEdgeMode;
  logic       edgeMode;
  logic       offMode;

  assign modeRd      = cfgRdData[3:1];
  assign oneEdgeMode = (modeRd == 3'd2) || (modeRd == 3'd3);
  assign edgeMode    = oneEdgeMode || (modeRd == 3'd6);
  assign offMode     = (modeRd == 3'd4) || (modeRd == 3'd5) || (modeRd == 3'd7);

  // R1
  reset_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !$past(rst_n)) |-> (modeRd == 3'd4));

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrEn |=> (modeRd == $past(cfgWrData[3:1])));

  // R2
  srst_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgRdData[4] == 1'b0);

  // R5
  level_high_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeRd == 3'd1) |-> (wakeEvent == cfgRdData[0]));

  // R4
  level_low_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeRd == 3'd0) |-> (wakeEvent == !cfgRdData[0]));

  // R6 R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oneEdgeMode && wakeEvent) |=> (!wakeEvent || !$stable(modeRd)));

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offMode |-> !wakeEvent);

  // R10
  srst_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfgWrEn && cfgWrData[4]) && edgeMode) |-> !wakeEvent);

endmodule

bind wake_pin_detector wpd_checker #(.CFG_W(CFG_W)) i_wpd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .cfgRdData (cfgRdData),
  .wakeEvent (wakeEvent)
);

// File: tb/test_wake_pin_detector.sv
module test_wake_pin_detector;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pinAsync = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic       wakeEvent;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wake_pin_detector i_wake_pin_detector (
    .clk       (clk),
    .rst_n     (rst_n),
    .pinAsync  (pinAsync),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .wakeEvent (wakeEvent)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    cfgWrEn   = 1'b1;
    cfgWrData = d;
    tick(1);
    cfgWrEn   = 1'b0;
    cfgWrData = '0;
  endtask

  task automatic setPin(input logic v);
    pinAsync = v;
    tick(4);
  endtask

  task automatic t_reset();
    check("R1", "mode", {5'd0, cfgRdData[3:1]}, 8'd4);
    check("R1", "event", {7'd0, wakeEvent}, 8'd0);
    check("R1", "srst bit", {7'd0, cfgRdData[4]}, 8'd0);
  endtask

  task automatic t_modeWrite();
    cfgWrite(8'hFF);
    check("R2", "mode after write", {5'd0, cfgRdData[3:1]}, 8'd7);
    check("R2", "upper bits", {3'd0, cfgRdData[7:4]}, 8'd0);
    cfgWrite(8'h0A);
    check("R2", "mode rewrite", {5'd0, cfgRdData[3:1]}, 8'd5);
  endtask

  task automatic t_readback();
    setPin(1'b0);
    pinAsync = 1'b1;
    tick(1);
    check("R3", "pin after 1", {7'd0, cfgRdData[0]}, 8'd0);
    tick(1);
    check("R3", "pin after 2", {7'd0, cfgRdData[0]}, 8'd1);
    pinAsync = 1'b0;
    tick(2);
    check("R3", "pin low after 2", {7'd0, cfgRdData[0]}, 8'd0);
  endtask

  task automatic t_level(input logic pol, input string req);
    setPin(pol);
    setPin(~pol);
    cfgWrite({4'd0, 2'd0, pol, 1'b0});
    check(req, "no match", {7'd0, wakeEvent}, 8'd0);
    pinAsync = pol;
    tick(1);
    check(req, "not yet", {7'd0, wakeEvent}, 8'd0);
    for (int i = 0; i < 4; i++) begin
      tick(1);
      check(req, "held level", {7'd0, wakeEvent}, 8'd1);
    end
    pinAsync = ~pol;
    tick(2);
    check(req, "released", {7'd0, wakeEvent}, 8'd0);
  endtask

  // expects one pulse exactly two edges after a pin change when fire is set
  task automatic edgeStep(input logic v, input logic fire, input string req);
    pinAsync = v;
    tick(1);
    check(req, "before pulse", {7'd0, wakeEvent}, 8'd0);
    tick(1);
    check(req, "pulse", {7'd0, wakeEvent}, {7'd0, fire});
    tick(1);
    check(req, "after pulse", {7'd0, wakeEvent}, 8'd0);
    tick(1);
  endtask

  task automatic t_edges();
    setPin(1'b1);
    cfgWrite(8'h04);           // mode 2 falling
    edgeStep(1'b0, 1'b1, "R6");
    edgeStep(1'b1, 1'b0, "R6");
    cfgWrite(8'h06);           // mode 3 rising
    edgeStep(1'b0, 1'b0, "R7");
    edgeStep(1'b1, 1'b1, "R7");
    cfgWrite(8'h0C);           // mode 6 any change
    edgeStep(1'b0, 1'b1, "R8");
    edgeStep(1'b1, 1'b1, "R8");
  endtask

  task automatic t_off();
    for (int m = 4; m < 8; m++) begin
      if (m == 6) continue;
      cfgWrite(8'(m << 1));
      for (int k = 0; k < 2; k++) begin
        pinAsync = ~pinAsync;
        for (int c = 0; c < 4; c++) begin
          tick(1);
          check("R9", "quiet in disabled mode", {7'd0, wakeEvent}, 8'd0);
        end
      end
    end
  endtask

  task automatic t_softReset();
    setPin(1'b0);
    cfgWrite(8'h06);
    pinAsync  = 1'b1;          // transition enters with the reset write
    cfgWrite(8'h16);           // mode 3 plus detector reset
    check("R10", "srst reads 0", {7'd0, cfgRdData[4]}, 8'd0);
    check("R10", "mode kept", {5'd0, cfgRdData[3:1]}, 8'd3);
    for (int c = 0; c < 4; c++) begin
      check("R10", "in-flight edge dropped", {7'd0, wakeEvent}, 8'd0);
      tick(1);
    end
    setPin(1'b0);
    edgeStep(1'b1, 1'b1, "R10");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_modeWrite();
    t_readback();
    t_level(1'b0, "R4");
    t_level(1'b1, "R5");
    t_edges();
    t_off();
    t_softReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule